// File: doc/BRIEF.md
# Crypto Coprocessor Instruction Sequencer

This block carries out the coprocessor instructions that a small controller writes to it. It holds four 128-bit working registers in a two-read-port bank and moves data through them one 32-bit quarter per cycle: filling a register from an input FIFO, draining one to an output FIFO, incrementing a counter field, combining two registers under a mask, and comparing two registers. It also hands operands to an AES engine and a GHASH engine and collects their results. Both engines sit outside the block and are seen only through start, acknowledge and idle handshakes.

A busy flag rises when an instruction is accepted and falls when the instruction's target has taken it. Starting an engine does not wait for that engine to finish, so AES and GHASH can run at the same time. A separate fetch instruction for each engine waits until that engine is idle and then stores the engine's result. A clear-output input empties the external output FIFO, so that data failing authentication never reaches the host.

Top module: `cop_sequencer`

## Requirements
- R1: An instruction byte is `{opcode[7:4], A[3:2], B[1:0]}`. A write on `instr_wr` while `busy` is low is accepted, and `busy` is high in the following cycle. A write while `busy` is high is ignored and leaves no pending instruction.
- R2: Opcodes are 0 LOAD, 1 WRITE, 2 LOADH, 3 SGFM, 4 FGFM, 5 SAES, 6 FAES, 7 INC, 8 XOR and 9 EQU. Codes 10 to 15 do nothing. Every instruction handles one 32-bit quarter per cycle, bits 31:0 first, and keeps `busy` high for exactly four cycles when its target never stalls. While `busy` is low, no FIFO or engine strobe is active.
- R3: LOAD pops four words from the input FIFO into register A, with the first word going to bits 31:0. It stalls without popping while `in_empty` is high.
- R4: WRITE pushes the four words of register A to the output FIFO, bits 31:0 first. It stalls without pushing while `out_full` is high.
- R5: INC adds one to bits 15:0 of register A, wrapping within those 16 bits. Bits 127:16 are unchanged.
- R6: XOR writes `(A xor B) and xor_mask` into register B. Register A is unchanged.
- R7: EQU sets `equ_flag` to 1 when registers A and B are equal on all 128 bits and to 0 otherwise. The flag holds its value until the next EQU completes.
- R8: SAES, SGFM and LOADH raise their engine strobe (`aes_start`, `gh_start` or `gh_load_h`) only in the fourth step. During that step `eng_operand` equals register A. The strobe is held until the engine acknowledges it, and `busy` falls in the cycle after the acknowledge, whether or not the engine is idle.
- R9: FAES and FGFM stall while the named engine's idle input is low. Once it is high, they copy that engine's 128-bit result into register A. The other engine's idle state has no effect on them.
- R10: `out_flush` follows `clr_out`. While `clr_out` is high, `out_wr` stays low and WRITE steps are discarded.
- R11: After reset, all four registers hold zero, and `busy`, `equ_flag` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_wr | input | 1 | Instruction write strobe |
| instr | input | 8 | Opcode, A address, B address |
| busy | output | 1 | Instruction in progress |
| xor_mask | input | 128 | Mask applied by XOR |
| equ_flag | output | 1 | Result of the last EQU |
| in_data | input | 32 | Input FIFO head word |
| in_empty | input | 1 | Input FIFO empty |
| in_rd | output | 1 | Input FIFO pop |
| out_data | output | 32 | Word to the output FIFO |
| out_full | input | 1 | Output FIFO full |
| out_wr | output | 1 | Output FIFO push |
| clr_out | input | 1 | Request to discard output data |
| out_flush | output | 1 | Output FIFO clear |
| eng_operand | output | 128 | Register A sent to the engines |
| aes_start | output | 1 | AES start request |
| aes_ack | input | 1 | AES accepted its start |
| aes_idle | input | 1 | AES engine idle, result valid |
| aes_result | input | 128 | AES result |
| gh_start | output | 1 | GHASH iteration request |
| gh_load_h | output | 1 | GHASH hash-key load request |
| gh_ack | input | 1 | GHASH accepted its request |
| gh_idle | input | 1 | GHASH engine idle, result valid |
| gh_result | input | 128 | GHASH result |

## Verification
The properties assume that the FIFO flags are honest and that an engine raises its acknowledge only while its own strobe is high. The bench's engine models respect both assumptions: the GHASH acknowledge is gated by its strobes, and the AES acknowledge is driven only after the bench has seen `aes_start` high. The properties also assume that `instr_wr` is a single-cycle pulse from the controller. The stimulus drives it for exactly one cycle per instruction, and drives it while `busy` is high only in the test that checks such writes are dropped.

// File: rtl/cop_pkg.sv
// Shared encodings of the coprocessor instruction sequencer.
// Assumes an 8-bit instruction: 4-bit opcode, 2-bit A address, 2-bit B address.
package cop_pkg;
    localparam int OPC_W   = 4;
    localparam int REG_AW  = 2;
    localparam int NUM_REGS = 2 ** REG_AW;
    localparam int INSTR_W = OPC_W + 2 * REG_AW;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 4'd0,
        OP_WRITE = 4'd1,
        OP_LOADH = 4'd2,
        OP_SGFM  = 4'd3,
        OP_FGFM  = 4'd4,
        OP_SAES  = 4'd5,
        OP_FAES  = 4'd6,
        OP_INC   = 4'd7,
        OP_XOR   = 4'd8,
        OP_EQU   = 4'd9
    } cop_op_e;

    typedef struct packed {
        cop_op_e             op;
        logic [REG_AW-1:0]   ra;
        logic [REG_AW-1:0]   rb;
    } cop_instr_t;
endpackage

// File: rtl/cop_bank.sv
// Working register bank: NUM_REGS lines of NUM_WORDS words each.
// Two full-line read ports (A and B) and one word-wide write port.
// Assumes at most one word is written per cycle.
module cop_bank #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int NUM_REGS  = 4,
    localparam int LINE_W   = WORD_W * NUM_WORDS,
    localparam int Q_W      = $clog2(NUM_WORDS),
    localparam int RA_W     = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RA_W-1:0]   wr_reg,
    input  logic [Q_W-1:0]    wr_q,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [RA_W-1:0]   rd_a,
    input  logic [RA_W-1:0]   rd_b,
    output logic [LINE_W-1:0] rd_a_line,
    output logic [LINE_W-1:0] rd_b_line
);
    logic [LINE_W-1:0] mem [NUM_REGS];

    // Purpose: clear all lines on reset, else write one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_reg][wr_q*WORD_W +: WORD_W] <= wr_data;
        end
    end

    assign rd_a_line = mem[rd_a];
    assign rd_b_line = mem[rd_b];
endmodule

// File: rtl/cop_step.sv
// Step counter: one pass over NUM_WORDS quarters per accepted instruction.
// Advances one quarter per cycle in which the target reports ready.
// Assumes 'start' is only looked at while idle.
module cop_step #(
    parameter int NUM_WORDS = 4,
    localparam int Q_W      = $clog2(NUM_WORDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           ready,
    output logic           active,
    output logic [Q_W-1:0] q,
    output logic           last_q
);
    localparam logic [Q_W-1:0] Q_LAST = Q_W'(NUM_WORDS - 1);

    assign last_q = (q == Q_LAST);

    // Purpose: track whether an instruction runs and which quarter it is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            q      <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                q      <= '0;
            end
        end else if (ready) begin
            q <= q + 1'b1;
            if (last_q) active <= 1'b0;
        end
    end
endmodule

// File: rtl/cop_alu.sv
// Word-wide operation unit: selects the value and target of the bank write
// for the current quarter, and compares the A and B words.
// Assumes the caller gates the write with step-ready.
module cop_alu
    import cop_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int Q_W    = 2
) (
    input  cop_op_e           op,
    input  logic [Q_W-1:0]    q,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    input  logic [WORD_W-1:0] mask_w,
    input  logic [WORD_W-1:0] fifo_w,
    input  logic [WORD_W-1:0] eng_w,
    output logic              wr_en,
    output logic              to_b,
    output logic [WORD_W-1:0] wr_data,
    output logic              words_eq
);
    // Purpose: decide what the current quarter writes back.
    always_comb begin
        wr_en    = 1'b0;
        to_b     = 1'b0;
        wr_data  = word_a;
        words_eq = (word_a == word_b);
        case (op)
            OP_LOAD: begin
                wr_en   = 1'b1;
                wr_data = fifo_w;
            end
            OP_FAES, OP_FGFM: begin
                wr_en   = 1'b1;
                wr_data = eng_w;
            end
            OP_INC: begin
                wr_en = 1'b1;
                if (q == '0) wr_data = {word_a[WORD_W-1:16], word_a[15:0] + 16'd1};
            end
            OP_XOR: begin
                wr_en   = 1'b1;
                to_b    = 1'b1;
                wr_data = (word_a ^ word_b) & mask_w;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cop_sequencer.sv
// Coprocessor instruction sequencer. Latches one instruction, walks its
// four quarters, talks to the FIFOs and to the AES/GHASH handshakes.
// Assumes engines raise ack only while their strobe is high.
module cop_sequencer
    import cop_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    localparam int LINE_W   = WORD_W * NUM_WORDS,
    localparam int Q_W      = $clog2(NUM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_wr,
    input  logic [INSTR_W-1:0] instr,
    output logic               busy,
    input  logic [LINE_W-1:0]  xor_mask,
    output logic               equ_flag,
    input  logic [WORD_W-1:0]  in_data,
    input  logic               in_empty,
    output logic               in_rd,
    output logic [WORD_W-1:0]  out_data,
    input  logic               out_full,
    output logic               out_wr,
    input  logic               clr_out,
    output logic               out_flush,
    output logic [LINE_W-1:0]  eng_operand,
    output logic               aes_start,
    input  logic               aes_ack,
    input  logic               aes_idle,
    input  logic [LINE_W-1:0]  aes_result,
    output logic               gh_start,
    output logic               gh_load_h,
    input  logic               gh_ack,
    input  logic               gh_idle,
    input  logic [LINE_W-1:0]  gh_result
);
    cop_instr_t          cur;
    logic                active, last_q, ready, step, accept;
    logic [Q_W-1:0]      q;
    logic [LINE_W-1:0]   line_a, line_b, eng_line;
    logic [WORD_W-1:0]   word_a, word_b, mask_w, eng_w, alu_data;
    logic                alu_we, alu_to_b, words_eq, eq_acc, eq_run;

    assign accept = instr_wr && !active;
    assign step   = active && ready;
    assign busy   = active;

    // Purpose: hold the accepted instruction for its whole run.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur <= '0;
        else if (accept) cur <= cop_instr_t'(instr);
    end

    cop_step #(.NUM_WORDS(NUM_WORDS)) u_step (
        .clk(clk), .rst_n(rst_n), .start(accept), .ready(ready),
        .active(active), .q(q), .last_q(last_q)
    );

    // Purpose: decide whether the current quarter may complete this cycle.
    always_comb begin
        case (cur.op)
            OP_LOAD:           ready = !in_empty;
            OP_WRITE:          ready = !out_full;
            OP_LOADH, OP_SGFM: ready = !last_q || gh_ack;
            OP_SAES:           ready = !last_q || aes_ack;
            OP_FAES:           ready = aes_idle;
            OP_FGFM:           ready = gh_idle;
            default:           ready = 1'b1;
        endcase
    end

    cop_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(step && alu_we),
        .wr_reg(alu_to_b ? cur.rb : cur.ra), .wr_q(q), .wr_data(alu_data),
        .rd_a(cur.ra), .rd_b(cur.rb), .rd_a_line(line_a), .rd_b_line(line_b)
    );

    assign eng_line = (cur.op == OP_FAES) ? aes_result : gh_result;
    assign word_a   = line_a[q*WORD_W +: WORD_W];
    assign word_b   = line_b[q*WORD_W +: WORD_W];
    assign mask_w   = xor_mask[q*WORD_W +: WORD_W];
    assign eng_w    = eng_line[q*WORD_W +: WORD_W];

    cop_alu #(.WORD_W(WORD_W), .Q_W(Q_W)) u_alu (
        .op(cur.op), .q(q), .word_a(word_a), .word_b(word_b), .mask_w(mask_w),
        .fifo_w(in_data), .eng_w(eng_w), .wr_en(alu_we), .to_b(alu_to_b),
        .wr_data(alu_data), .words_eq(words_eq)
    );

    assign eq_run = (q == '0) ? words_eq : (eq_acc && words_eq);

    // Purpose: fold per-quarter compares and publish the flag on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_acc   <= 1'b0;
            equ_flag <= 1'b0;
        end else if (step && cur.op == OP_EQU) begin
            eq_acc <= eq_run;
            if (last_q) equ_flag <= eq_run;
        end
    end

    assign in_rd       = active && cur.op == OP_LOAD && !in_empty;
    assign out_wr      = active && cur.op == OP_WRITE && !out_full && !clr_out;
    assign out_data    = word_a;
    assign out_flush   = clr_out;
    assign eng_operand = line_a;
    assign aes_start   = active && last_q && cur.op == OP_SAES;
    assign gh_start    = active && last_q && cur.op == OP_SGFM;
    assign gh_load_h   = active && last_q && cur.op == OP_LOADH;
endmodule

// File: rtl/cop_sequencer_chk.sv
// Property checker for cop_sequencer, bound to every instance.
// Assumes the environment rules stated in the brief.
module cop_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic instr_wr,
    input logic busy,
    input logic equ_flag,
    input logic in_empty,
    input logic in_rd,
    input logic out_full,
    input logic out_wr,
    input logic clr_out,
    input logic aes_start,
    input logic aes_ack,
    input logic gh_start,
    input logic gh_load_h
);
    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        instr_wr && !busy |=> busy); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(in_rd || out_wr || aes_start || gh_start || gh_load_h)); // R2
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |-> !in_empty); // R3
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr |-> !out_full); // R4
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !instr_wr |=> $stable(equ_flag)); // R7
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({aes_start, gh_start, gh_load_h})); // R8
    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        aes_start && !aes_ack |=> aes_start); // R8
    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        aes_start && aes_ack |=> !busy); // R8
    AST_CLEAR_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        clr_out |-> !out_wr); // R10
endmodule

bind cop_sequencer cop_sequencer_chk u_chk (.*);

// File: tb/cop_sequencer_test.sv
`timescale 1ns/1ps
module cop_sequencer_test;
    typedef struct packed {
        logic [3:0]   op;
        logic [1:0]   ra;
        logic [1:0]   rb;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] mask;
        logic [127:0] exp;
    } vec_t;

    localparam logic [127:0] ONES = {128{1'b1}};
    localparam logic [127:0] XA = 128'hFFFFFFFF_00000000_12345678_AAAAAAAA;
    localparam logic [127:0] XB = 128'h0F0F0F0F_FFFFFFFF_12345678_55555555;
    localparam logic [127:0] EQV = 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00D;
    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'd7, 2'd0, 2'd1, 128'h0, 128'h0, 128'h0, 128'h1},
        '{4'd7, 2'd2, 2'd0, 128'h11112222_33334444_5555AAAA_1234FFFF, 128'h0, 128'h0,
          128'h11112222_33334444_5555AAAA_12340000},
        '{4'd7, 2'd1, 2'd3, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_ABCD0010, 128'h0, 128'h0,
          128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_ABCD0011},
        '{4'd8, 2'd0, 2'd1, XA, XB, ONES, 128'hF0F0F0F0_FFFFFFFF_00000000_FFFFFFFF},
        '{4'd8, 2'd3, 2'd2, XA, XB, 128'hFFFF0000_FFFF0000_FFFF0000_FFFF0000,
          128'hF0F00000_FFFF0000_00000000_FFFF0000},
        '{4'd9, 2'd0, 2'd3, EQV, EQV, 128'h0, 128'h1},
        '{4'd9, 2'd1, 2'd2, EQV, 128'h5EADBEEF_01234567_89ABCDEF_CAFEF00D, 128'h0, 128'h0},
        '{4'd9, 2'd2, 2'd0, EQV, 128'hDEADBEEF_01234567_89ABCDEF_CAFEF00C, 128'h0, 128'h0},
        '{4'd9, 2'd3, 2'd1, XB, XB, 128'h0, 128'h1}
    };

    logic clk = 1'b0, rst_n = 1'b0, instr_wr = 1'b0;
    logic [7:0] instr = '0;
    logic [127:0] xor_mask = '0, aes_result = '0, gh_result = '0;
    logic busy, equ_flag, in_rd, out_wr, out_flush, aes_start, gh_start, gh_load_h;
    logic [31:0] in_data, out_data;
    logic [127:0] eng_operand;
    logic in_empty, out_full = 1'b0, clr_out = 1'b0;
    logic aes_ack = 1'b0, aes_idle = 1'b1, gh_ack, gh_idle = 1'b1, gh_ack_auto = 1'b1;
    logic hold_empty = 1'b0;
    logic [31:0] src [4];
    logic [31:0] cap [8];
    int src_ptr = 4, cap_n = 0, n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    assign in_empty = hold_empty || (src_ptr >= 4);
    assign in_data  = src[src_ptr[1:0]];
    assign gh_ack   = gh_ack_auto && (gh_start || gh_load_h);

    // FIFO models: pop the source, capture pushed words.
    always @(posedge clk) begin
        if (in_rd) src_ptr <= src_ptr + 1;
        if (out_wr) begin
            cap[cap_n[2:0]] <= out_data;
            cap_n <= cap_n + 1;
        end
    end

    cop_sequencer uut (.*);

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [1:0] ra, input logic [1:0] rb);
        @(negedge clk);
        instr_wr = 1'b1;
        instr = {op, ra, rb};
        @(negedge clk);
        instr_wr = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic load_reg(input logic [1:0] r, input logic [127:0] v);
        int n;
        for (int i = 0; i < 4; i++) src[i] = v[i*32 +: 32];
        src_ptr = 0;
        issue(4'd0, r, 2'd0);
        wait_idle(n);
    endtask

    task automatic write_reg(input logic [1:0] r, output logic [127:0] v, output int n);
        cap_n = 0;
        issue(4'd1, r, 2'd0);
        wait_idle(n);
        v = {cap[3], cap[2], cap[1], cap[0]};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] got;
        int n;
        for (int i = 0; i < 4; i++) src[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state at the ports
        chk(!busy && !equ_flag && !in_rd && !out_wr, "R11 idle outputs", {busy, equ_flag}, 0);
        chk(!aes_start && !gh_start && !gh_load_h, "R11 strobes", {aes_start, gh_start, gh_load_h}, 0);
        write_reg(2'd2, got, n);
        chk(got == 128'h0, "R11 register cleared", got, 0);
        chk(n == 4 && cap_n == 4, "R4 write takes four cycles, four pushes", n, 4);

        // Table: operate and compare (R2 cycle count, R5/R6/R7 result)
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            logic [1:0] dst;
            load_reg(t.ra, t.a);
            if (t.rb != t.ra) load_reg(t.rb, t.b);
            xor_mask = t.mask;
            issue(t.op, t.ra, t.rb);
            wait_idle(n);
            chk(n == 4, "R2 four-cycle instruction", n, 4);
            if (t.op == 4'd9) begin
                chk(equ_flag == t.exp[0], "R7 equality flag", equ_flag, t.exp[0]);
            end else begin
                dst = (t.op == 4'd8) ? t.rb : t.ra;
                write_reg(dst, got, n);
                chk(got == t.exp, (t.op == 4'd8) ? "R6 masked xor into B" : "R5 increment low 16 bits", got, t.exp);
                if (t.op == 4'd8) begin
                    write_reg(t.ra, got, n);
                    chk(got == t.a, "R6 register A unchanged", got, t.a);
                end
            end
        end

        // R3: LOAD stalls on empty FIFO, low quarter first
        for (int i = 0; i < 4; i++) src[i] = 32'hA0000000 + i;
        src_ptr = 0;
        hold_empty = 1'b1;
        issue(4'd0, 2'd1, 2'd0);
        repeat (5) @(negedge clk);
        chk(busy && !in_rd && src_ptr == 0, "R3 load stalls while empty", src_ptr, 0);
        hold_empty = 1'b0;
        wait_idle(n);
        chk(n == 4, "R3 load resumes", n, 4);
        write_reg(2'd1, got, n);
        chk(got == 128'hA0000003_A0000002_A0000001_A0000000, "R3 word order", got,
            128'hA0000003_A0000002_A0000001_A0000000);

        // R4: WRITE stalls on full FIFO
        cap_n = 0;
        out_full = 1'b1;
        issue(4'd1, 2'd1, 2'd0);
        repeat (5) @(negedge clk);
        chk(busy && !out_wr && cap_n == 0, "R4 write stalls while full", cap_n, 0);
        out_full = 1'b0;
        wait_idle(n);
        chk(n == 4 && cap[0] == 32'hA0000000 && cap[3] == 32'hA0000003, "R4 write resumes in order", cap[0], 32'hA0000000);

        // R1: instruction written while busy is dropped
        for (int i = 0; i < 4; i++) src[i] = 32'h00050000 + i;
        src_ptr = 0;
        hold_empty = 1'b1;
        issue(4'd0, 2'd0, 2'd0);
        @(negedge clk);
        instr_wr = 1'b1;
        instr = {4'd7, 2'd0, 2'd0};
        @(negedge clk);
        instr_wr = 1'b0;
        hold_empty = 1'b0;
        wait_idle(n);
        repeat (3) @(negedge clk);
        chk(!busy, "R1 no pending instruction", busy, 0);
        write_reg(2'd0, got, n);
        chk(got == 128'h00050003_00050002_00050001_00050000, "R1 ignored INC", got,
            128'h00050003_00050002_00050001_00050000);

        // R2: unused opcode completes in four cycles with no strobes
        issue(4'd12, 2'd0, 2'd0);
        wait_idle(n);
        chk(n == 4, "R2 unused opcode", n, 4);

        // R8: SAES strobe in last step, held until ack, non-blocking
        aes_idle = 1'b0;
        load_reg(2'd2, 128'h0BADF00D_13572468_FEEDFACE_76543210);
        issue(4'd5, 2'd2, 2'd0);
        n = 1;
        while (!aes_start && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(n == 4, "R8 start only in fourth step", n, 4);
        chk(eng_operand == 128'h0BADF00D_13572468_FEEDFACE_76543210, "R8 operand is register A",
            eng_operand, 128'h0BADF00D_13572468_FEEDFACE_76543210);
        repeat (3) @(negedge clk);
        chk(busy && aes_start, "R8 start held until ack", {busy, aes_start}, 2'b11);
        aes_ack = 1'b1;
        @(negedge clk);
        aes_ack = 1'b0;
        chk(!busy && !aes_start, "R8 ack clears busy with engine running", {busy, aes_start}, 0);

        // R8: LOADH and SGFM while AES still runs
        issue(4'd2, 2'd2, 2'd0);
        n = 1;
        while (!gh_load_h && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(n == 4 && eng_operand == 128'h0BADF00D_13572468_FEEDFACE_76543210, "R8 hash key load", n, 4);
        wait_idle(n);
        issue(4'd3, 2'd2, 2'd0);
        wait_idle(n);
        chk(n == 4, "R8 GHASH start accepted with AES busy", n, 4);

        // R9: FGFM completes while AES busy; FAES stalls until AES idle
        gh_result = 128'h99998888_77776666_55554444_33332222;
        issue(4'd4, 2'd3, 2'd0);
        wait_idle(n);
        chk(n == 4, "R9 FGFM ignores AES state", n, 4);
        write_reg(2'd3, got, n);
        chk(got == gh_result, "R9 GHASH result stored", got, gh_result);
        aes_result = 128'h01020304_05060708_090A0B0C_0D0E0F10;
        issue(4'd6, 2'd1, 2'd0);
        repeat (5) @(negedge clk);
        chk(busy, "R9 FAES waits for idle", busy, 1);
        aes_idle = 1'b1;
        wait_idle(n);
        chk(n == 4, "R9 FAES resumes", n, 4);
        write_reg(2'd1, got, n);
        chk(got == aes_result, "R9 AES result stored", got, aes_result);

        // R10: clear-output suppresses pushes
        clr_out = 1'b1;
        cap_n = 0;
        issue(4'd1, 2'd1, 2'd0);
        chk(out_flush && !out_wr, "R10 flush follows clear", out_flush, 1);
        wait_idle(n);
        chk(n == 4 && cap_n == 0, "R10 no words pushed", cap_n, 0);
        clr_out = 1'b0;
        @(negedge clk);
        chk(!out_flush, "R10 flush released", out_flush, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule